// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This peripheral produces a burst of a programmed number of clock pulses on a single output, for use as the configuration clock of a programmable fabric. Software talks to it through a plain 32-bit register port with two registers: a count register whose write starts a burst, and a status register that holds a sticky completion flag.

The usual sequence is to clear the completion flag, write the pulse count, poll the flag until it reads 1, and clear it again. Each output pulse is derived from the system clock by a fixed divide. A high phase lasts `HALF_DIV` system cycles and a low phase lasts `HALF_DIV` cycles. Typical bursts are a few hundred pulses for flushing errors, and up to 2047 pulses ahead of data streaming.

The engine is a four-state machine:
- `ST_IDLE`: the output is low and nothing runs.
- `ST_HIGH`: the output is high. It moves to `ST_LOW` at the end of a half period.
- `ST_LOW`: the output is low. At the end of a half period it returns to `ST_HIGH` if pulses remain, or moves to `ST_WRAP` after the last pulse.
- `ST_WRAP`: a single cycle that raises the completion flag. It then moves to `ST_IDLE`.

A count write overrides every state. It enters `ST_HIGH` for a non-zero count, or `ST_WRAP` for zero.

Top module: `cburst_gen`

## Requirements
- R1: After reset the done flag is 0, `cfg_clk_out` is low, and a read of the count register returns 0.
- R2: A write to byte offset 0x08 starts a burst of exactly N pulses, where N is `bus_wdata[CNT_W-1:0]` and the bits above it are ignored. `cfg_clk_out` is high in the cycle right after the write edge.
- R3: Each pulse is high for `HALF_DIV` cycles and then low for `HALF_DIV` cycles. The done flag first reads 1 exactly 2*HALF_DIV*N+1 cycles after the write edge.
- R4: Bit 0 of the status register at byte offset 0x0C is the done flag. It is set only at the end of a burst and holds its value until it is cleared.
- R5: Writing 1 to status bit 0 clears the done flag. Writing 0 to it leaves the flag unchanged.
- R6: A count of 0 emits no pulse and sets the done flag one cycle after the write edge.
- R7: A count write while a burst is running abandons that burst and starts over with the new count. The abandoned burst never sets the done flag.
- R8: If a clear write lands in the same cycle that a burst ends, the done flag is set.
- R9: A read of offset 0x08 returns the number of pulses not yet completed. Reads of other unmapped offsets return 0, and writes to them change nothing.
- R10: `cfg_clk_out` stays low whenever no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cfg_clk_out | output | 1 | Burst clock output |

## Verification
The checker assumes a single-cycle write strobe. It also assumes that after a zero-count write, the next cycle carries no further count write. Otherwise the one-cycle `ST_WRAP` step that the zero-count property expects would be overridden.

The stimulus drives the bus on falling edges and holds each write for exactly one rising edge. Status polling uses side-effect-free reads. Restarts are only issued while a non-zero burst is running.

// File: rtl/cburst_pkg.sv
package cburst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_WRAP = 2'd3
    } burst_state_e;

    localparam logic [7:0] OFS_COUNT  = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
endpackage

// File: rtl/cburst_halfdiv.sv
module cburst_halfdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    generate
        if (HALF <= 1) begin : g_direct
            // every cycle ends a half period
            assign tick = run && !restart;
        end else begin : g_count
            localparam int W = $clog2(HALF);
            localparam logic [W-1:0] LAST = W'(HALF - 1);
            logic [W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt <= '0;
                else if (restart || !run || cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = run && !restart && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/cburst_engine.sv
module cburst_engine
    import cburst_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int HALF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    output logic             pulse,
    output logic             fin,
    output logic             busy,
    output logic [CNT_W-1:0] remaining
);
    burst_state_e state, nxt;
    logic         tick;

    cburst_halfdiv #(.HALF(HALF)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (busy),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
        end else begin
            state <= nxt;
            if (start)
                remaining <= start_cnt;
            else if (state == ST_LOW && tick)
                remaining <= remaining - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = ST_IDLE;
            ST_HIGH: if (tick) nxt = ST_LOW;
            ST_LOW:  if (tick) nxt = (remaining == CNT_W'(1)) ? ST_WRAP : ST_HIGH;
            ST_WRAP: nxt = ST_IDLE;
        endcase
        if (start)
            nxt = (start_cnt == '0) ? ST_WRAP : ST_HIGH;
    end

    // outputs
    always_comb begin
        pulse = (state == ST_HIGH);
        fin   = (state == ST_WRAP);
        busy  = (state == ST_HIGH) || (state == ST_LOW);
    end
endmodule

// File: rtl/cburst_gen.sv
module cburst_gen
    import cburst_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 12,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cfg_clk_out
);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic             sel_count, sel_status;
    logic             wr_count, clr_done, count_zero;
    logic             fin, busy, pulse, done_q;
    logic [CNT_W-1:0] remaining;

    assign sel_count  = (bus_addr == A_COUNT);
    assign sel_status = (bus_addr == A_STATUS);
    assign wr_count   = bus_wr && sel_count;
    assign clr_done   = bus_wr && sel_status && bus_wdata[0];
    assign count_zero = (bus_wdata[CNT_W-1:0] == '0);

    cburst_engine #(.CNT_W(CNT_W), .HALF(HALF_DIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_count),
        .start_cnt (bus_wdata[CNT_W-1:0]),
        .pulse     (pulse),
        .fin       (fin),
        .busy      (busy),
        .remaining (remaining)
    );

    // sticky completion flag: completion outranks clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (fin)
            done_q <= 1'b1;
        else if (clr_done)
            done_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_count)
            bus_rdata[CNT_W-1:0] = remaining;
        else if (sel_status)
            bus_rdata[0] = done_q;
    end

    assign cfg_clk_out = pulse;
endmodule

// File: rtl/cburst_chk.sv
module cburst_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_count,
    input logic count_zero,
    input logic clr_done,
    input logic fin,
    input logic busy,
    input logic done_q,
    input logic cfg_clk_out
);
    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !clr_done |=> done_q);
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done && !fin |=> !done_q);
    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q);
    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(fin));
    // R2
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count && !count_zero |=> cfg_clk_out);
    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count && count_zero |=> fin && !cfg_clk_out);
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cfg_clk_out);
endmodule

bind cburst_gen cburst_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_count    (wr_count),
    .count_zero  (count_zero),
    .clr_done    (clr_done),
    .fin         (fin),
    .busy        (busy),
    .done_q      (done_q),
    .cfg_clk_out (cfg_clk_out)
);

// File: tb/cburst_gen_tb.sv
`timescale 1ns/1ps
module cburst_gen_tb;
    localparam int HALF = 2;
    localparam logic [7:0] A_CNT = 8'h08;
    localparam logic [7:0] A_ST  = 8'h0C;
    localparam int NVEC = 6;
    // each entry: {raw write data, expected pulse count}
    localparam logic [31:0] VEC_DATA [NVEC] = '{32'd1, 32'd3, 32'd7, 32'hFFFF_F005, 32'd256, 32'h7FF};
    localparam int          VEC_N    [NVEC] = '{1, 3, 7, 5, 256, 2047};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_clk_out;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    cburst_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cfg_clk_out (cfg_clk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // write count, then watch until done; returns cycles, pulses, high cycles
    task automatic burst(input logic [31:0] d, output int cyc, output int pls, output int hi);
        logic [31:0] v;
        logic prev;
        prev = 1'b0; cyc = 0; pls = 0; hi = 0;
        wr(A_CNT, d);
        while (cyc < 20000) begin
            rd(A_ST, v);
            if (v[0]) break;
            if (cfg_clk_out && !prev) pls++;
            if (cfg_clk_out) hi++;
            prev = cfg_clk_out;
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc, pls, hi;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_ST, v);  check("R1 done", v, 0);
        rd(A_CNT, v); check("R1 count", v, 0);
        check("R1 clk", {31'd0, cfg_clk_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            wr(A_ST, 32'd1);
            rd(A_ST, v); check("R5 pre-clear", v, 0);
            burst(VEC_DATA[i], cyc, pls, hi);
            check("R2 pulses", pls, VEC_N[i]);
            check("R3 high cycles", hi, HALF * VEC_N[i]);
            check("R3 done latency", cyc, 2 * HALF * VEC_N[i] + 1);
            rd(A_CNT, v); check("R9 idle count", v, 0);
            check("R10 idle low", {31'd0, cfg_clk_out}, 0);
            wr(A_ST, 32'd1);
            rd(A_ST, v); check("R5 clear", v, 0);
        end

        // R6 zero count
        burst(32'd0, cyc, pls, hi);
        check("R6 no pulse", pls, 0);
        check("R6 latency", cyc, 1);

        // R5 writing 0 keeps done; R9 unmapped offset ignored
        wr(A_ST, 32'd0);
        rd(A_ST, v); check("R5 write0 keeps", v, 1);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(A_ST, v); check("R9 unmapped write", v, 1);
        rd(8'h10, v); check("R9 unmapped read", v, 0);
        check("R9 no burst", {31'd0, cfg_clk_out}, 0);
        wr(A_ST, 32'd1);

        // R9 remaining count read-back
        wr(A_CNT, 32'd3);
        rd(A_CNT, v); check("R9 remaining start", v, 3);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); check("R9 remaining after one", v, 2);
        repeat (9) @(negedge clk);
        rd(A_ST, v); check("R9 burst done", v, 1);
        wr(A_ST, 32'd1);

        // R7 restart
        wr(A_CNT, 32'd5);
        repeat (6) @(negedge clk);
        rd(A_ST, v); check("R7 running no done", v, 0);
        burst(32'd2, cyc, pls, hi);
        check("R7 restart pulses", pls, 2);
        check("R7 restart latency", cyc, 2 * HALF * 2 + 1);
        wr(A_ST, 32'd1);

        // R8 clear collides with completion
        wr(A_CNT, 32'd1);
        repeat (4) @(negedge clk);
        wr(A_ST, 32'd1);
        rd(A_ST, v); check("R8 set wins", v, 1);
        wr(A_ST, 32'd1);
        rd(A_ST, v); check("R8 later clear", v, 0);

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule